// File: doc/BRIEF.md
# External Wakeup Interrupt Controller

This block gathers 32 asynchronous external request pins into interrupts for a processor. The pins form four banks of eight. Each line has its own trigger selector, choosing between low level, high level, falling edge, rising edge or both edges. Every line owns a pending flag, which sets when its trigger condition occurs. Software clears the flag by writing a one to it. A per-line mask bit decides whether a pending flag reaches an output.

The lower sixteen lines each drive a dedicated interrupt output. The upper sixteen lines share one combined output. Software therefore services the upper lines by reading the two upper pending registers, clearing from them the bits that are set in the matching mask registers, and walking the bits that remain. All registers sit on a flat register bus with a combinational read port.

Top module: `ext_wake_intc`

## Requirements
- R1: Line n uses bank n>>3 and bit n&7 of that bank's registers. A register address is {kind[1:0], bank[1:0]}, where kind 0 is the control register, kind 1 is the mask register and kind 2 is the pending register. Kind 3 reads as zero. Mask and pending reads return zero above bit 7.
- R2: Reset is synchronous and active low. While it is held, all mask bits read 1, all pending bits read 0 and all control fields read 000.
- R3: A mask bit of 1 blocks its line from the outputs. A mask bit of 0 lets it through. A pending flag still sets while its line is masked.
- R4: Writing a 1 to a pending bit clears it. Writing a 0 leaves that bit unchanged.
- R5: Line k of a bank has a 3-bit trigger selector at control bits [4k+2:4k]. Bit 4k+3 always reads 0. A write loads all eight fields of the bank.
- R6: Selector 011 sets pending on a 0-to-1 transition of the synchronized pin. Selector 010 sets pending on a 1-to-0 transition.
- R7: Any selector with bit 2 set sets pending on a transition in either direction.
- R8: Selector 001 (high level) or 000 (low level) sets pending on every cycle the level holds. If a hardware set and a clear write hit the same bit in the same cycle, the bit stays set.
- R9: Output irq_line_o[n], for n from 0 to 15, is high exactly while line n is pending and unmasked.
- R10: irq_shared_o is high exactly while some line from 16 to 31 is pending and unmasked.
- R11: A pin change applied before clock edge 1 shows in pending after edge 3: two edges for the synchronizer and one to latch the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 32 | Asynchronous external request pins |
| reg_addr_i | input | 4 | Register address {kind, bank} |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_line_o | output | 16 | Dedicated interrupts for lines 0 to 15 |
| irq_shared_o | output | 1 | Combined interrupt for lines 16 to 31 |

## Verification
A hardware set of a pending flag and a software clear of that same flag can land in one clock cycle. The bench provokes this by holding a line at its active level under a level trigger and writing a clear to that line's pending bit. Because the condition re-arms on every cycle, the set and the clear coincide. The pending bit is read in the cycle right after the write and must still be 1. After the pin returns to its inactive level, a second clear must leave the bit at 0.

// File: rtl/xwi_pkg.sv
// Shared types and the trigger evaluation function for the external
// wakeup interrupt controller. Assumes a 3-bit selector per line.
package xwi_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        TRIG_LOW  = 3'b000,
        TRIG_HIGH = 3'b001,
        TRIG_FALL = 3'b010,
        TRIG_RISE = 3'b011,
        TRIG_BOTH = 3'b100
    } trig_e;

    typedef enum logic [1:0] {
        KIND_CTRL = 2'd0,
        KIND_MASK = 2'd1,
        KIND_PEND = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;

    // Decide whether a line's trigger condition holds this cycle.
    function automatic logic trig_hit(logic [SEL_W-1:0] sel, logic cur, logic prev);
        logic hit;
        if (sel[2]) begin
            hit = cur ^ prev;
        end else begin
            case (sel[1:0])
                2'b00:   hit = ~cur;
                2'b01:   hit = cur;
                2'b10:   hit = prev & ~cur;
                default: hit = cur & ~prev;
            endcase
        end
        return hit;
    endfunction

endpackage

// File: rtl/xwi_sync.sv
// Two-flop synchronizer with one extra stage that holds the previous
// synchronized value for edge detection. Assumes pins are fully async.
module xwi_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    // Shift pins through metastability, sync and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pins_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/xwi_bank.sv
// One bank of lines: trigger selectors, mask and pending registers.
// Assumes synchronized inputs and write strobes decoded by the parent.
// A hardware set beats a software clear in the same cycle.
module xwi_bank
    import xwi_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int STRIDE = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LINES-1:0]        sync_i,
    input  logic [LINES-1:0]        prev_i,
    input  logic                    ctrl_we_i,
    input  logic                    mask_we_i,
    input  logic                    pend_we_i,
    input  logic [LINES*STRIDE-1:0] wdata_i,
    output logic [LINES*STRIDE-1:0] ctrl_o,
    output logic [LINES-1:0]        mask_o,
    output logic [LINES-1:0]        pend_o
);

    localparam int PAD_W = STRIDE - SEL_W;

    logic [LINES-1:0] hit;
    logic [LINES-1:0] mask_q;
    logic [LINES-1:0] pend_q;
    logic [LINES-1:0] clr;

    for (genvar k = 0; k < LINES; k++) begin : g_line
        logic [SEL_W-1:0] sel_q;

        // Hold this line's trigger selector.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q <= '0;
            end else if (ctrl_we_i) begin
                sel_q <= wdata_i[k*STRIDE +: SEL_W];
            end
        end

        assign ctrl_o[k*STRIDE +: STRIDE] = {{PAD_W{1'b0}}, sel_q};
        assign hit[k] = trig_hit(sel_q, sync_i[k], prev_i[k]);
    end

    // Mask register, all lines blocked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_we_i) begin
            mask_q <= wdata_i[LINES-1:0];
        end
    end

    // Select the pending bits a write-one-to-clear access targets.
    always_comb begin
        clr = pend_we_i ? wdata_i[LINES-1:0] : '0;
    end

    // Pending flags: clear on write one, set by trigger, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | hit;
        end
    end

    assign mask_o = mask_q;
    assign pend_o = pend_q;

endmodule

// File: rtl/ext_wake_intc.sv
// External wakeup interrupt controller top. Synchronizes the pins,
// instantiates one bank per group of lines, decodes the register bus
// and forms dedicated and shared interrupt outputs.
// Assumes a single clock domain for the register bus.
module ext_wake_intc
    import xwi_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int BANK_LINES   = 8,
    parameter int FIELD_STRIDE = 4,
    parameter int DIRECT_LINES = 16,
    localparam int NUM_LINES   = NUM_BANKS * BANK_LINES,
    localparam int BANK_W      = $clog2(NUM_BANKS),
    localparam int ADDR_W      = BANK_W + 2,
    localparam int DATA_W      = BANK_LINES * FIELD_STRIDE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_LINES-1:0]    pins_i,
    input  logic [ADDR_W-1:0]       reg_addr_i,
    input  logic                    reg_we_i,
    input  logic [DATA_W-1:0]       reg_wdata_i,
    output logic [DATA_W-1:0]       reg_rdata_o,
    output logic [DIRECT_LINES-1:0] irq_line_o,
    output logic                    irq_shared_o
);

    localparam int SHARED_LINES = NUM_LINES - DIRECT_LINES;

    logic [NUM_LINES-1:0] sync_all;
    logic [NUM_LINES-1:0] prev_all;
    logic [NUM_LINES-1:0] pend_all;
    logic [NUM_LINES-1:0] mask_all;
    logic [NUM_LINES-1:0] active;
    logic [DATA_W-1:0]    ctrl_rd [NUM_BANKS];
    reg_kind_e            kind;
    logic [BANK_W-1:0]    bank_sel;

    assign kind     = reg_kind_e'(reg_addr_i[ADDR_W-1 -: 2]);
    assign bank_sel = reg_addr_i[BANK_W-1:0];

    xwi_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .sync_o (sync_all),
        .prev_o (prev_all)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel_here;
        assign sel_here = reg_we_i && (bank_sel == BANK_W'(b));

        xwi_bank #(.LINES(BANK_LINES), .STRIDE(FIELD_STRIDE)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_i    (sync_all[b*BANK_LINES +: BANK_LINES]),
            .prev_i    (prev_all[b*BANK_LINES +: BANK_LINES]),
            .ctrl_we_i (sel_here && (kind == KIND_CTRL)),
            .mask_we_i (sel_here && (kind == KIND_MASK)),
            .pend_we_i (sel_here && (kind == KIND_PEND)),
            .wdata_i   (reg_wdata_i),
            .ctrl_o    (ctrl_rd[b]),
            .mask_o    (mask_all[b*BANK_LINES +: BANK_LINES]),
            .pend_o    (pend_all[b*BANK_LINES +: BANK_LINES])
        );
    end

    // Return the addressed register, zero-extended for narrow ones.
    always_comb begin
        reg_rdata_o = '0;
        case (kind)
            KIND_CTRL: reg_rdata_o = ctrl_rd[bank_sel];
            KIND_MASK: reg_rdata_o[BANK_LINES-1:0] = mask_all[bank_sel*BANK_LINES +: BANK_LINES];
            KIND_PEND: reg_rdata_o[BANK_LINES-1:0] = pend_all[bank_sel*BANK_LINES +: BANK_LINES];
            default:   reg_rdata_o = '0;
        endcase
    end

    assign active       = pend_all & ~mask_all;
    assign irq_line_o   = active[DIRECT_LINES-1:0];
    assign irq_shared_o = |active[NUM_LINES-1 -: SHARED_LINES];

endmodule

// File: rtl/xwi_checker.sv
// Property checker for the external wakeup interrupt controller.
// Assumes it is bound into ext_wake_intc and sees its pending and mask vectors.
module xwi_checker #(
    parameter int NUM_LINES    = 32,
    parameter int BANK_LINES   = 8,
    parameter int DIRECT_LINES = 16,
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       reg_addr_i,
    input logic                    reg_we_i,
    input logic [DATA_W-1:0]       reg_wdata_i,
    input logic [DATA_W-1:0]       reg_rdata_o,
    input logic [DIRECT_LINES-1:0] irq_line_o,
    input logic                    irq_shared_o,
    input logic [NUM_LINES-1:0]    pend_all,
    input logic [NUM_LINES-1:0]    mask_all
);

    localparam int NUM_BANKS = NUM_LINES / BANK_LINES;
    localparam int BANK_W    = ADDR_W - 2;

    logic [NUM_LINES-1:0] clr_vec;

    // Collect the bits a pending-clear write targets this cycle.
    always_comb begin
        clr_vec = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_we_i && reg_addr_i[ADDR_W-1 -: 2] == 2'd2 &&
                reg_addr_i[BANK_W-1:0] == BANK_W'(b)) begin
                clr_vec[b*BANK_LINES +: BANK_LINES] = reg_wdata_i[BANK_LINES-1:0];
            end
        end
    end

    // R2: a cycle in reset leaves masks set and pendings clear.
    a_r2_reset_values: assert property (@(posedge clk)
        !rst_n |=> (pend_all == '0 && mask_all == '1));

    // R4: a pending flag falls only after a clear write to that bit.
    a_r4_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_all) & ~pend_all & ~$past(clr_vec)) == '0));

    // R3: a masked line never shows on a dedicated output.
    a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_line_o & mask_all[DIRECT_LINES-1:0]) == '0));

    // R10: the shared output needs an unmasked pending upper line.
    a_r10_shared_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_shared_o |-> (|(pend_all[NUM_LINES-1:DIRECT_LINES] & ~mask_all[NUM_LINES-1:DIRECT_LINES])));

    // R1: mask and pending reads are zero above the bank width.
    a_r1_narrow_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i[ADDR_W-1 -: 2] == 2'd1 || reg_addr_i[ADDR_W-1 -: 2] == 2'd2)
        |-> (reg_rdata_o[DATA_W-1:BANK_LINES] == '0));

endmodule

bind ext_wake_intc xwi_checker #(
    .NUM_LINES    (NUM_LINES),
    .BANK_LINES   (BANK_LINES),
    .DIRECT_LINES (DIRECT_LINES),
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr_i   (reg_addr_i),
    .reg_we_i     (reg_we_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .irq_line_o   (irq_line_o),
    .irq_shared_o (irq_shared_o),
    .pend_all     (pend_all),
    .mask_all     (mask_all)
);

// File: tb/sim_ext_wake_intc.sv
module sim_ext_wake_intc;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] CTRL_DEFAULT = 32'h3333_3333;
    // Vector fields: {line[4:0], selector[2:0], pin_before, pin_after, expect_pending}
    localparam int NVEC = 9;
    localparam logic [10:0] VEC [NVEC] = '{
        {5'd3,  3'b011, 1'b0, 1'b1, 1'b1},
        {5'd3,  3'b011, 1'b1, 1'b0, 1'b0},
        {5'd12, 3'b010, 1'b1, 1'b0, 1'b1},
        {5'd12, 3'b010, 1'b0, 1'b1, 1'b0},
        {5'd20, 3'b100, 1'b0, 1'b1, 1'b1},
        {5'd27, 3'b111, 1'b1, 1'b0, 1'b1},
        {5'd9,  3'b001, 1'b0, 1'b1, 1'b1},
        {5'd30, 3'b000, 1'b1, 1'b0, 1'b1},
        {5'd5,  3'b001, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] irq_line;
    logic        irq_shared;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_wake_intc u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .pins_i       (pins),
        .reg_addr_i   (addr),
        .reg_we_i     (we),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .irq_line_o   (irq_line),
        .irq_shared_o (irq_shared)
    );

    function automatic logic [3:0] ra(input logic [1:0] kind, input logic [1:0] bank);
        return {kind, bank};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a; we = 1'b0;
        #1;
        d = rdata;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        for (int b = 0; b < 4; b++) wr(ra(2'd2, 2'(b)), 32'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R2: values held during reset
        for (int b = 0; b < 4; b++) begin
            rd(ra(2'd1, 2'(b)), v); check("R2 mask reset", v, 32'hFF);
            rd(ra(2'd2, 2'(b)), v); check("R2 pending reset", v, 32'h0);
            rd(ra(2'd0, 2'(b)), v); check("R2 control reset", v, 32'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R5: reserved bit per field reads 0, whole register loads
        wr(ra(2'd0, 2'd1), 32'hFFFF_FFFF);
        rd(ra(2'd0, 2'd1), v); check("R5 field isolation", v, 32'h7777_7777);
        for (int b = 0; b < 4; b++) wr(ra(2'd0, 2'(b)), CTRL_DEFAULT);
        clear_all();
        rd(ra(2'd3, 2'd0), v); check("R1 unused kind reads zero", v, 32'h0);

        // Vector walk: R1 mapping with R6/R7/R8 triggers, R9/R10 outputs
        for (int i = 0; i < NVEC; i++) begin
            int line; int bnk; int bt;
            logic [2:0] mode; logic pre; logic post; logic exp;
            logic [31:0] c;
            line = int'(VEC[i][10:6]); mode = VEC[i][5:3];
            pre = VEC[i][2]; post = VEC[i][1]; exp = VEC[i][0];
            bnk = line >> 3; bt = line & 7;
            pins[line] = pre;
            wait_edges(4);
            c = (CTRL_DEFAULT & ~(32'hF << (bt*4))) | (32'(mode) << (bt*4));
            wr(ra(2'd0, 2'(bnk)), c);
            clear_all();
            rd(ra(2'd2, 2'(bnk)), v); check("R4 cleared before stimulus", 32'(v[bt]), 32'h0);
            pins[line] = post;
            wait_edges(3);
            rd(ra(2'd2, 2'(bnk)), v);
            if (mode[2]) check("R1 R7 both edges", 32'(v[bt]), 32'(exp));
            else if (mode[1]) check("R1 R6 edge trigger", 32'(v[bt]), 32'(exp));
            else check("R1 R8 level trigger", 32'(v[bt]), 32'(exp));
            wr(ra(2'd1, 2'(bnk)), 32'(~(8'h1 << bt)));
            if (line < 16) check("R9 dedicated output", 32'(irq_line[line]), 32'(exp));
            else check("R10 shared output", 32'(irq_shared), 32'(exp));
            wr(ra(2'd1, 2'(bnk)), 32'hFF);
            wr(ra(2'd0, 2'(bnk)), CTRL_DEFAULT);
        end

        // R4: write of zero keeps flags, write of one clears only its bit
        clear_all();
        pins[1] = 1'b1; pins[2] = 1'b1;
        wait_edges(3);
        rd(ra(2'd2, 2'd0), v); check("R4 two flags set", v & 32'h6, 32'h6);
        check("R3 masked pending gives no output", 32'(irq_line[2]), 32'h0);
        wr(ra(2'd2, 2'd0), 32'h0);
        rd(ra(2'd2, 2'd0), v); check("R4 zero write keeps flags", v & 32'h6, 32'h6);
        wr(ra(2'd2, 2'd0), 32'h2);
        rd(ra(2'd2, 2'd0), v); check("R4 one write clears only its bit", v & 32'h6, 32'h4);
        wr(ra(2'd1, 2'd0), 32'hFB);
        check("R9 only unmasked line drives", 32'(irq_line), 32'h0004);
        check("R10 shared idle with lower line", 32'(irq_shared), 32'h0);
        wr(ra(2'd1, 2'd0), 32'hFF);

        // R8: level set wins over clear in same cycle
        clear_all();
        pins[9] = 1'b1;
        wr(ra(2'd0, 2'd1), 32'h3333_3313);
        wait_edges(1);
        wr(ra(2'd2, 2'd1), 32'h2);
        rd(ra(2'd2, 2'd1), v); check("R8 set wins over clear", 32'(v[1]), 32'h1);
        pins[9] = 1'b0;
        wait_edges(3);
        wr(ra(2'd2, 2'd1), 32'h2);
        rd(ra(2'd2, 2'd1), v); check("R8 clear holds once level gone", 32'(v[1]), 32'h0);
        wr(ra(2'd0, 2'd1), CTRL_DEFAULT);

        // R10: combined output of upper banks
        clear_all();
        pins[17] = 1'b1; pins[26] = 1'b1;
        wait_edges(3);
        check("R3 masked upper lines silent", 32'(irq_shared), 32'h0);
        wr(ra(2'd1, 2'd3), 32'hFB);
        check("R10 bank3 line drives shared", 32'(irq_shared), 32'h1);
        wr(ra(2'd1, 2'd3), 32'hFF);
        wr(ra(2'd1, 2'd2), 32'hFD);
        check("R10 bank2 line drives shared", 32'(irq_shared), 32'h1);
        check("R9 lower outputs unaffected", 32'(irq_line), 32'h0);
        wr(ra(2'd1, 2'd2), 32'hFF);
        check("R10 shared drops when masked", 32'(irq_shared), 32'h0);

        // R11: three-edge latency from pin to pending
        clear_all();
        pins[0] = 1'b1;
        wait_edges(2);
        rd(ra(2'd2, 2'd0), v); check("R11 not yet pending after two edges", 32'(v[0]), 32'h0);
        wait_edges(1);
        rd(ra(2'd2, 2'd0), v); check("R11 pending after three edges", 32'(v[0]), 32'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule